// File: doc/BRIEF.md
# Key-Guarded Watchdog and Interval Timer

This block is a 16-bit up-counter with two jobs. In watchdog mode it must be restarted by software before it reaches the selected limit, or it requests a system reset. In interval mode the same limit sets a timer interrupt flag instead. The counter is driven by one of two clock-enable strobes, a fast one and a slow one, which come from clock generators outside the block. Four expiry limits are available, at 2^15, 2^13, 2^9 and 2^6 strobes.

All configuration is held in one control word, written over a simple register bus. The upper byte of every write to that word must carry a key value. A write that carries any other value is discarded and raises a one-cycle reset request. The key never appears on reads, because a fixed, different constant is returned in its place.

A second function is the external reset/NMI pin. In reset function, a low pin requests a reset. In NMI function, a chosen edge of the pin sets an NMI flag instead. The timer and NMI flags each have an enable bit that gates their interrupt output. Software clears the flags by writing the flag register.

Top module: `wdt_guard`

## Requirements
- R1: A write to the control word (address 0) is applied only when bits 15:8 equal 0x5A. Reading address 0 always returns 0x69 in bits 15:8.
- R2: A control write whose bits 15:8 are not 0x5A leaves the control word unchanged. It drives `rst_req` high for exactly the one cycle after the write edge.
- R3: The control word has these fields: bits 1:0 tap, bit 2 clock source, bit 3 counter clear, bit 4 mode (0 watchdog, 1 interval), bit 5 pin function (0 reset, 1 NMI), bit 6 NMI edge (0 rising, 1 falling), bit 7 hold. Bit 3 always reads as 0.
- R4: Counting from zero, expiry happens on the 2^15th counted strobe for tap 00, the 2^13th for tap 01, the 2^9th for tap 10 and the 2^6th for tap 11. It never happens on the strobe before.
- R5: Bit 2 = 0 counts `fast_tick` and bit 2 = 1 counts `slow_tick`. Strobes of the source that is not selected are ignored.
- R6: An accepted control write with bit 3 set restarts the count from zero.
- R7: While bit 7 is set, the counter does not advance.
- R8: In watchdog mode, expiry drives `rst_req` high for one cycle, in the cycle after the edge that took the final strobe. The counter then restarts from zero.
- R9: In interval mode, expiry sets flag bit 0 one edge later and gives no reset request. `timer_irq` is flag bit 0 AND enable bit 0.
- R10: In NMI function, the selected edge of `nmi_pin` sets flag bit 4 on the edge that first sees the new pin level. The other edge does not set it. `nmi_irq` is flag bit 4 AND enable bit 4.
- R11: In reset function, pin edges set no flag. `rst_req` is high starting one edge after the pin is sampled low, and stays high while the pin is low.
- R12: After reset, the control word reads 0x6900 (watchdog mode, tap 00, fast source, reset pin function, running). The enable and flag registers read 0, and `rst_req` is low while the pin is high.
- R13: Address 1 holds the enable bits and address 2 holds the flag bits, both at bits 0 and 4. Other bits read 0. A write to address 2 loads both flags, so writing 0 clears them. A flag-setting event in the same cycle wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_tick | input | 1 | Fast count strobe, one clk cycle wide |
| slow_tick | input | 1 | Slow count strobe, one clk cycle wide |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 enable, 2 flags) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| nmi_pin | input | 1 | External reset/NMI pin, already synchronous |
| rst_req | output | 1 | Reset request |
| timer_irq | output | 1 | Timer interrupt |
| nmi_irq | output | 1 | NMI interrupt |

## Verification
Each result has a fixed latency. The count advances on the edge that samples a strobe. An expiry shows on `rst_req` in the cycle right after the edge that took the final strobe, and the timer flag appears one edge later. A bad-key request appears right after the write edge. The NMI flag and the pin reset request appear right after the edge that first sees the new pin level. The bench drives exact strobe counts, one on each edge. It samples at the falling edge that follows the relevant rising edge, and it reads flags one cycle later still, so each check lands in the cycle where its value is due. Reset requests are also counted at every falling edge, which catches a pulse that is too early, too late or doubled.

// File: rtl/wdtp_pkg.sv
package wdtp_pkg;

    localparam logic [7:0] KEY_WRITE = 8'h5A;
    localparam logic [7:0] KEY_READ  = 8'h69;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_IEN  = 2'd1,
        ADDR_FLAG = 2'd2
    } reg_addr_e;

    // Field order follows bit positions 7 down to 0 of the control word.
    typedef struct packed {
        logic       hold;
        logic       nmi_fall;
        logic       pin_nmi;
        logic       interval;
        logic       clr;
        logic       slow_src;
        logic [1:0] tap;
    } ctrl_t;

    // Event bits: nmi sits at word bit 4, tmr at word bit 0.
    typedef struct packed {
        logic nmi;
        logic tmr;
    } evt_t;

    function automatic evt_t evt_from_word(input logic [15:0] w);
        evt_t e;
        e.nmi = w[4];
        e.tmr = w[0];
        return e;
    endfunction

    function automatic logic [15:0] evt_to_word(input evt_t e);
        logic [15:0] w;
        w    = '0;
        w[4] = e.nmi;
        w[0] = e.tmr;
        return w;
    endfunction

endpackage

// File: rtl/wdtp_ctrl.sv
module wdtp_ctrl
    import wdtp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output ctrl_t       ctrl,
    output logic        clr_pulse,
    output logic        key_fault
);

    logic  key_ok;
    logic  accept;
    ctrl_t ctrl_q;
    ctrl_t ctrl_d;

    assign key_ok    = (wr_data[15:8] == KEY_WRITE);
    assign accept    = wr_en && key_ok;
    assign clr_pulse = accept && wr_data[3];

    always_comb begin
        ctrl_d     = ctrl_t'(wr_data[7:0]);
        ctrl_d.clr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            key_fault <= 1'b0;
        end else begin
            key_fault <= wr_en && !key_ok;
            if (accept) begin
                ctrl_q <= ctrl_d;
            end
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/wdtp_counter.sv
module wdtp_counter
    import wdtp_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TAP0_EXP = 15,
    parameter int TAP1_EXP = 13,
    parameter int TAP2_EXP = 9,
    parameter int TAP3_EXP = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fast_tick,
    input  logic             slow_tick,
    input  ctrl_t            ctrl,
    input  logic             clr_pulse,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    localparam logic [CNT_W-1:0] LAST0 = CNT_W'((64'd1 << TAP0_EXP) - 64'd1);
    localparam logic [CNT_W-1:0] LAST1 = CNT_W'((64'd1 << TAP1_EXP) - 64'd1);
    localparam logic [CNT_W-1:0] LAST2 = CNT_W'((64'd1 << TAP2_EXP) - 64'd1);
    localparam logic [CNT_W-1:0] LAST3 = CNT_W'((64'd1 << TAP3_EXP) - 64'd1);

    logic [CNT_W-1:0] last;
    logic             tick;
    logic             advance;

    always_comb begin
        unique case (ctrl.tap)
            2'b00:   last = LAST0;
            2'b01:   last = LAST1;
            2'b10:   last = LAST2;
            default: last = LAST3;
        endcase
    end

    assign tick    = ctrl.slow_src ? slow_tick : fast_tick;
    assign advance = tick && !ctrl.hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (clr_pulse) begin
                cnt <= '0;
            end else if (advance) begin
                if (cnt >= last) begin
                    cnt    <= '0;
                    expire <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wdtp_pin.sv
module wdtp_pin
    import wdtp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    input  ctrl_t ctrl,
    output logic  edge_hit,
    output logic  pin_rst
);

    logic pin_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b1;
        end else begin
            pin_q <= pin;
        end
    end

    assign rise     = pin && !pin_q;
    assign fall     = !pin && pin_q;
    assign edge_hit = ctrl.pin_nmi && (ctrl.nmi_fall ? fall : rise);
    assign pin_rst  = !ctrl.pin_nmi && !pin_q;

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdtp_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TAP0_EXP = 15,
    parameter int TAP1_EXP = 13,
    parameter int TAP2_EXP = 9,
    parameter int TAP3_EXP = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fast_tick,
    input  logic        slow_tick,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        nmi_pin,
    output logic        rst_req,
    output logic        timer_irq,
    output logic        nmi_irq
);

    ctrl_t            ctrl;
    logic             clr_pulse;
    logic             key_fault;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic             edge_hit;
    logic             pin_rst;
    evt_t             ien_q;
    evt_t             flg_q;
    evt_t             flg_d;
    reg_addr_e        addr;

    assign addr = reg_addr_e'(bus_addr);

    wdtp_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_we && (addr == ADDR_CTRL)),
        .wr_data   (bus_wdata),
        .ctrl      (ctrl),
        .clr_pulse (clr_pulse),
        .key_fault (key_fault)
    );

    wdtp_counter #(
        .CNT_W    (CNT_W),
        .TAP0_EXP (TAP0_EXP),
        .TAP1_EXP (TAP1_EXP),
        .TAP2_EXP (TAP2_EXP),
        .TAP3_EXP (TAP3_EXP)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick),
        .ctrl      (ctrl),
        .clr_pulse (clr_pulse),
        .cnt       (cnt),
        .expire    (expire)
    );

    wdtp_pin u_pin (
        .clk      (clk),
        .rst      (rst),
        .pin      (nmi_pin),
        .ctrl     (ctrl),
        .edge_hit (edge_hit),
        .pin_rst  (pin_rst)
    );

    always_comb begin
        flg_d = flg_q;
        if (bus_we && (addr == ADDR_FLAG)) begin
            flg_d = evt_from_word(bus_wdata);
        end
        if (expire && ctrl.interval) begin
            flg_d.tmr = 1'b1;
        end
        if (edge_hit) begin
            flg_d.nmi = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
            if (bus_we && (addr == ADDR_IEN)) begin
                ien_q <= evt_from_word(bus_wdata);
            end
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_CTRL: bus_rdata = {KEY_READ, 8'(ctrl)};
            ADDR_IEN:  bus_rdata = evt_to_word(ien_q);
            ADDR_FLAG: bus_rdata = evt_to_word(flg_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign rst_req   = key_fault || (expire && !ctrl.interval) || pin_rst;
    assign timer_irq = flg_q.tmr && ien_q.tmr;
    assign nmi_irq   = flg_q.nmi && ien_q.nmi;

endmodule

// File: rtl/wdt_guard_checker.sv
module wdt_guard_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [15:0]      bus_wdata,
    input logic [15:0]      bus_rdata,
    input logic             nmi_pin,
    input logic             rst_req,
    input logic [7:0]       ctrl_bits,
    input logic [CNT_W-1:0] cnt,
    input logic             expire,
    input logic [1:0]       flag_bits
);

    logic bad_key_wr;
    logic ctrl_wr;

    assign ctrl_wr    = bus_we && (bus_addr == 2'd0);
    assign bad_key_wr = ctrl_wr && (bus_wdata[15:8] != 8'h5A);

    AST_KEY_READBACK: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd0) |-> (bus_rdata[15:8] == 8'h69)); // R1

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd0) |-> !bus_rdata[3]); // R3

    AST_BADKEY_RESET: assert property (@(posedge clk) disable iff (rst)
        bad_key_wr |=> rst_req); // R2

    AST_BADKEY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        bad_key_wr |=> (ctrl_bits == $past(ctrl_bits))); // R2

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_bits[7] && !ctrl_wr) |=> (cnt == $past(cnt))); // R7

    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire); // R8

    AST_TIMER_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl_bits[4]) |=> flag_bits[0]); // R9

    AST_NMI_FALL_SET: assert property (@(posedge clk) disable iff (rst)
        (ctrl_bits[5] && ctrl_bits[6] && $fell(nmi_pin)) |=> flag_bits[1]); // R10

endmodule

bind wdt_guard wdt_guard_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .nmi_pin   (nmi_pin),
    .rst_req   (rst_req),
    .ctrl_bits (8'(ctrl)),
    .cnt       (cnt),
    .expire    (expire),
    .flag_bits (2'(flg_q))
);

// File: tb/wdt_guard_tb.sv
`timescale 1ns/1ps
module wdt_guard_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fast_tick = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        nmi_pin = 1'b1;
    logic        rst_req;
    logic        timer_irq;
    logic        nmi_irq;

    int n_chk = 0;
    int n_bad = 0;
    int rst_seen = 0;

    always #2 clk = ~clk;

    wdt_guard u_dut (
        .clk       (clk),
        .rst       (rst),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .nmi_pin   (nmi_pin),
        .rst_req   (rst_req),
        .timer_irq (timer_irq),
        .nmi_irq   (nmi_irq)
    );

    always @(negedge clk) if (!rst && rst_req) rst_seen++;

    // {ctrl[34:19], strobes[18:3], slow[2], exp_rst[1], exp_flag[0]}
    localparam int NV = 10;
    localparam logic [34:0] VEC [NV] = '{
        {16'h5A1B, 16'd63,   1'b0, 1'b0, 1'b0},  // R4 tap 11, one short
        {16'h5A1B, 16'd64,   1'b0, 1'b0, 1'b1},  // R4 R9 interval expiry
        {16'h5A0B, 16'd64,   1'b0, 1'b1, 1'b0},  // R8 watchdog expiry
        {16'h5A0B, 16'd63,   1'b0, 1'b0, 1'b0},  // R8 one short
        {16'h5A1A, 16'd512,  1'b0, 1'b0, 1'b1},  // R4 tap 10
        {16'h5A1A, 16'd511,  1'b0, 1'b0, 1'b0},  // R4 tap 10 short
        {16'h5A1F, 16'd64,   1'b1, 1'b0, 1'b1},  // R5 slow source
        {16'h5A1F, 16'd64,   1'b0, 1'b0, 1'b0},  // R5 unselected ignored
        {16'h5A9B, 16'd64,   1'b0, 1'b0, 1'b0},  // R7 hold
        {16'h5A19, 16'd8192, 1'b0, 1'b0, 1'b1}   // R4 tap 01
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n, input bit slow);
        if (n > 0) begin
            @(negedge clk);
            if (slow) slow_tick = 1'b1; else fast_tick = 1'b1;
            repeat (n) @(posedge clk);
            @(negedge clk);
            fast_tick = 1'b0; slow_tick = 1'b0;
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] d;
        logic [34:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        rd(2'd0, d); chk("R12 ctrl", d, 16'h6900);
        rd(2'd1, d); chk("R12 ien", d, 16'h0000);
        rd(2'd2, d); chk("R12 flags", d, 16'h0000);
        chk("R12 rst_req", 16'(rst_req), 16'h0);

        // R4 R8 default longest tap in watchdog mode
        rst_seen = 0;
        ticks(32767, 1'b0);
        rd(2'd0, d); chk("R4 tap00 short", 16'(rst_seen), 16'd0);
        ticks(1, 1'b0);
        rd(2'd0, d); chk("R4 R8 tap00 expiry", 16'(rst_seen), 16'd1);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            wr(2'd0, v[34:19]);
            wr(2'd2, 16'h0000);
            rst_seen = 0;
            ticks(int'(v[18:3]), v[2]);
            rd(2'd2, d);
            chk("R4/R5/R7/R8 reset count", 16'(rst_seen), 16'(v[1]));
            chk("R4/R5/R7/R9 timer flag", d, v[0] ? 16'h0001 : 16'h0000);
        end

        // R1 R3 readback
        wr(2'd0, 16'h5A1B);
        rd(2'd0, d); chk("R1 R3 readback", d, 16'h6913);

        // R2 bad key
        wr(2'd0, 16'h33E4);
        chk("R2 fault pulse", 16'(rst_req), 16'h1);
        @(negedge clk); chk("R2 pulse ends", 16'(rst_req), 16'h0);
        rd(2'd0, d); chk("R2 ctrl kept", d, 16'h6913);

        // R6 clear restarts
        wr(2'd2, 16'h0000);
        ticks(40, 1'b0);
        wr(2'd0, 16'h5A1B);
        ticks(40, 1'b0);
        rd(2'd2, d); chk("R6 no early expiry", d, 16'h0000);
        ticks(24, 1'b0);
        rd(2'd2, d); chk("R6 expiry after restart", d, 16'h0001);

        // R9 R13 interrupt gating and software clear
        chk("R9 irq gated off", 16'(timer_irq), 16'h0);
        wr(2'd1, 16'h0001);
        chk("R9 irq on", 16'(timer_irq), 16'h1);
        wr(2'd2, 16'h0000);
        chk("R13 flag cleared", 16'(timer_irq), 16'h0);

        // R10 NMI falling edge selected
        wr(2'd0, 16'h5AE3);
        wr(2'd1, 16'hFFFF);
        rd(2'd1, d); chk("R13 ien bits", d, 16'h0011);
        @(negedge clk); nmi_pin = 1'b0;
        rd(2'd2, d); chk("R10 fall sets", d, 16'h0010);
        chk("R10 nmi_irq", 16'(nmi_irq), 16'h1);
        wr(2'd2, 16'h0000);
        @(negedge clk); nmi_pin = 1'b1;
        rd(2'd2, d); chk("R10 rise ignored", d, 16'h0000);
        // rising edge selected
        wr(2'd0, 16'h5AA3);
        @(negedge clk); nmi_pin = 1'b0;
        rd(2'd2, d); chk("R10 fall ignored", d, 16'h0000);
        @(negedge clk); nmi_pin = 1'b1;
        rd(2'd2, d); chk("R10 rise sets", d, 16'h0010);

        // R11 reset pin function
        wr(2'd0, 16'h5A83);
        wr(2'd2, 16'h0000);
        @(negedge clk); nmi_pin = 1'b0;
        @(negedge clk); chk("R11 pin low reset", 16'(rst_req), 16'h1);
        rd(2'd2, d); chk("R11 no flag", d, 16'h0000);
        chk("R11 still low", 16'(rst_req), 16'h1);
        @(negedge clk); nmi_pin = 1'b1;
        @(negedge clk); chk("R11 released", 16'(rst_req), 16'h0);

        summary();
    end

endmodule